// File: doc/BRIEF.md
# Configuration Port Unlock Gate

This block is the configuration front end of a legacy I/O controller. It sits behind a pair of byte-wide ports: an index port at the base address and a data port one address above it. While locked, the block passes nothing through. It watches every byte written to the index port for a four-byte unlock key. When it sees the whole key, it opens an indexed register file. That file holds a two-byte chip identifier, a logical-device selector, a flash-segment enable byte and, under logical device 7, the 16-bit base address of a serial-flash engine.

Software selects a register by writing its index to the index port and then reads or writes it through the data port. The final key byte depends on a strap input that tells the block which of its two possible base addresses it occupies. Software leaves configuration mode by writing a fixed value to a fixed register, not by sending another key. The serial-flash base address is also driven out continuously to the engine that uses it.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the block is locked (`cfgActive` = 0), `spiBase` is 0x0000 and `rdData` is 0xFF.
- R2: With `altBase` = 0, the index-port writes 0x87, 0x01, 0x55, 0x55 in that order unlock the block. `cfgActive` goes to 1 at the clock edge that takes the fourth byte.
- R3: With `altBase` = 1, the fourth key byte must be 0xAA. The sequence 0x87, 0x01, 0x55, 0x55 leaves the block locked.
- R4: An index-port byte that does not match the expected key byte restarts the match from the first byte. If that mismatching byte is 0x87, it counts as the first byte of a new attempt.
- R5: While locked, data-port reads return 0xFF and data-port writes change no register.
- R6: Index 0x20 reads 0x87 and index 0x21 reads 0x16, the high and low bytes of the identifier 0x8716.
- R7: Index 0x07 is a read/write logical-device selector. When it holds 0x07, index 0x64 (high byte) and index 0x65 (low byte) read and write `spiBase`. When it holds any other value, those indexes read 0x00 and ignore writes.
- R8: Index 0x24 is a read/write segment-enable byte that resets to 0x00 and keeps its value across lock and unlock.
- R9: A data-port write of 0x02 while the index is 0x02 locks the block. Any other value written to index 0x02 leaves it unlocked.
- R10: An index-port read returns the current index when unlocked and 0xFF when locked. A data-port read of an unassigned index returns 0x00.
- R11: `rdData` is loaded at the clock edge at which `rdEn` is high and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altBase | input | 1 | Strap: 0 = primary base address (last key byte 0x55), 1 = alternate base address (last key byte 0xAA) |
| portSel | input | 1 | 0 = index port, 1 = data port |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |
| cfgActive | output | 1 | High while configuration mode is open |
| spiBase | output | 16 | Serial-flash engine base address |

## Verification
A key-matcher step that is off by one shows at the ports within a single write. `cfgActive` then either rises one byte early or stays low after a valid key. Sequences with a repeated 0x87 or with the wrong strap byte expose a restart that goes to the wrong step. An index register or device selector that latches the wrong value shows on the very next data-port read, which returns the wrong register or a zero. A register that accepts writes while locked, or while another logical device is selected, shows on `spiBase` at the next edge.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int BYTE_W  = 8;
  localparam int KEY_LEN = 4;
  localparam int STEP_W  = $clog2(KEY_LEN);

  localparam logic [BYTE_W-1:0] KEY_B0      = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_B1      = 8'h01;
  localparam logic [BYTE_W-1:0] KEY_B2      = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_LAST_PRI = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_LAST_ALT = 8'hAA;

  localparam logic [BYTE_W-1:0] IDX_EXIT   = 8'h02;
  localparam logic [BYTE_W-1:0] VAL_EXIT   = 8'h02;
  localparam logic [BYTE_W-1:0] IDX_LDN    = 8'h07;
  localparam logic [BYTE_W-1:0] IDX_ID_HI  = 8'h20;
  localparam logic [BYTE_W-1:0] IDX_ID_LO  = 8'h21;
  localparam logic [BYTE_W-1:0] IDX_SEG    = 8'h24;
  localparam logic [BYTE_W-1:0] IDX_SPI_HI = 8'h64;
  localparam logic [BYTE_W-1:0] LDN_SPI    = 8'h07;

  localparam logic [BYTE_W-1:0] LOCKED_RD  = 8'hFF;

  typedef struct packed {
    logic idxLoad;
    logic regWrite;
    logic regRead;
    logic relock;
    logic active;
  } ctlStrobe_t;

  function automatic logic [BYTE_W-1:0] keyByte(input logic [STEP_W-1:0] step,
                                                input logic altSel);
    logic [BYTE_W-1:0] b;
    case (step)
      2'd0:    b = KEY_B0;
      2'd1:    b = KEY_B1;
      2'd2:    b = KEY_B2;
      default: b = altSel ? KEY_LAST_ALT : KEY_LAST_PRI;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              altBase,
  input  logic              portSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] curIndex,
  output ctlStrobe_t        strobe
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] step;
  logic              active;
  logic              idxWr;
  logic              dataWr;
  logic              keyHit;
  logic              restartHit;
  logic              exitHit;

  assign idxWr      = wrEn & ~portSel;
  assign dataWr     = wrEn & portSel;
  assign keyHit     = (wrData == keyByte(step, altBase));
  assign restartHit = (wrData == keyByte('0, altBase));
  assign exitHit    = active & dataWr & (curIndex == IDX_EXIT) & (wrData == VAL_EXIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step   <= '0;
      active <= 1'b0;
    end else if (!active) begin
      if (idxWr) begin
        if (keyHit) begin
          if (step == LAST_STEP) begin
            active <= 1'b1;
            step   <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end else if (restartHit) begin
          step <= STEP_W'(1);
        end else begin
          step <= '0;
        end
      end
    end else if (exitHit) begin
      active <= 1'b0;
      step   <= '0;
    end
  end

  always_comb begin
    strobe.idxLoad  = active & idxWr;
    strobe.regWrite = active & dataWr;
    strobe.regRead  = rdEn;
    strobe.relock   = exitHit;
    strobe.active   = active;
  end

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_port_pkg::*;
#(
  parameter logic [15:0]       ID_VALUE     = 16'h8716,
  parameter logic [15:0]       SPI_BASE_RST = 16'h0000,
  parameter logic [BYTE_W-1:0] SEG_RST      = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              portSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] curIndex,
  output logic [BYTE_W-1:0] rdData,
  output logic [15:0]       spiBase
);

  localparam int SPI_BYTES = 16 / BYTE_W;

  logic [BYTE_W-1:0] ldnReg;
  logic [BYTE_W-1:0] segReg;
  logic [BYTE_W-1:0] spiByte [SPI_BYTES];
  logic [BYTE_W-1:0] regVal;
  logic              spiSel;

  assign spiSel = (ldnReg == LDN_SPI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIndex <= '0;
    end else if (strobe.relock) begin
      curIndex <= '0;
    end else if (strobe.idxLoad) begin
      curIndex <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnReg <= '0;
      segReg <= SEG_RST;
    end else if (strobe.regWrite) begin
      if (curIndex == IDX_LDN) ldnReg <= wrData;
      if (curIndex == IDX_SEG) segReg <= wrData;
    end
  end

  for (genvar g = 0; g < SPI_BYTES; g++) begin : gSpiByte
    localparam logic [BYTE_W-1:0] MY_IDX = IDX_SPI_HI + BYTE_W'(g);
    localparam logic [BYTE_W-1:0] MY_RST = SPI_BASE_RST[15 - g*BYTE_W -: BYTE_W];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        spiByte[g] <= MY_RST;
      end else if (strobe.regWrite && spiSel && curIndex == MY_IDX) begin
        spiByte[g] <= wrData;
      end
    end
    assign spiBase[15 - g*BYTE_W -: BYTE_W] = spiByte[g];
  end

  always_comb begin
    case (curIndex)
      IDX_ID_HI: regVal = ID_VALUE[15:8];
      IDX_ID_LO: regVal = ID_VALUE[7:0];
      IDX_LDN:   regVal = ldnReg;
      IDX_SEG:   regVal = segReg;
      default:   regVal = '0;
    endcase
    for (int k = 0; k < SPI_BYTES; k++) begin
      if (spiSel && curIndex == IDX_SPI_HI + BYTE_W'(k)) regVal = spiByte[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= LOCKED_RD;
    end else if (strobe.regRead) begin
      if (!strobe.active)  rdData <= LOCKED_RD;
      else if (portSel)    rdData <= regVal;
      else                 rdData <= curIndex;
    end
  end

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] ID_VALUE     = 16'h8716,
  parameter logic [15:0] SPI_BASE_RST = 16'h0000,
  parameter logic [7:0]  SEG_RST      = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        altBase,
  input  logic        portSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        cfgActive,
  output logic [15:0] spiBase
);

  ctlStrobe_t        strobe;
  logic [BYTE_W-1:0] curIndex;

  cfg_unlock_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .altBase  (altBase),
    .portSel  (portSel),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wrData   (wrData),
    .curIndex (curIndex),
    .strobe   (strobe)
  );

  cfg_reg_file #(
    .ID_VALUE     (ID_VALUE),
    .SPI_BASE_RST (SPI_BASE_RST),
    .SEG_RST      (SEG_RST)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .portSel  (portSel),
    .wrData   (wrData),
    .curIndex (curIndex),
    .rdData   (rdData),
    .spiBase  (spiBase)
  );

  assign cfgActive = strobe.active;

endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker (
  input logic        clk,
  input logic        rstN,
  input logic        altBase,
  input logic        portSel,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic        cfgActive,
  input logic [15:0] spiBase,
  input logic [7:0]  curIndex
);

  // R2 / R3: configuration mode opens only on an index write of the strap-selected last key byte
  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgActive) |-> $past(wrEn && !portSel && wrData == (altBase ? 8'hAA : 8'h55)));

  // R9: configuration mode closes only through the exit write
  assert_exit_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgActive) |-> $past(wrEn && portSel && wrData == 8'h02 && curIndex == 8'h02));

  // R9: the exit write always closes
  assert_exit_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgActive && wrEn && portSel && curIndex == 8'h02 && wrData == 8'h02) |=> !cfgActive);

  // R5: locked reads return all ones
  assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !cfgActive) |=> rdData == 8'hFF);

  // R5: nothing written while locked reaches the flash base
  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgActive |=> $stable(spiBase));

  // R11: read byte holds without a read strobe
  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind cfg_access_port cfg_port_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .altBase   (altBase),
  .portSel   (portSel),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .cfgActive (cfgActive),
  .spiBase   (spiBase),
  .curIndex  (curIndex)
);

// File: tb/cfg_access_port_test.sv
`timescale 1ns/1ps
module cfg_access_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        altBase = 1'b0;
  logic        portSel = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        cfgActive;
  logic [15:0] spiBase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_access_port uut (
    .clk       (clk),
    .rstN      (rstN),
    .altBase   (altBase),
    .portSel   (portSel),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .cfgActive (cfgActive),
    .spiBase   (spiBase)
  );

  // vector: {isRead, portSel, byte (write data or expected read), expected cfgActive, requirement}
  function automatic logic [14:0] vw(input logic sel, input logic [7:0] d, input logic act, input logic [3:0] req);
    return {1'b0, sel, d, act, req};
  endfunction
  function automatic logic [14:0] vr(input logic sel, input logic [7:0] d, input logic act, input logic [3:0] req);
    return {1'b1, sel, d, act, req};
  endfunction

  localparam logic I = 1'b0;
  localparam logic D = 1'b1;
  localparam int NV = 58;
  localparam logic [14:0] VEC [NV] = '{
    vr(D, 8'hFF, 0, 5), vw(D, 8'h37, 0, 5), vr(D, 8'hFF, 0, 5),                      // R5 locked
    vw(I, 8'h87, 0, 2), vw(I, 8'h01, 0, 2), vw(I, 8'h55, 0, 2), vw(I, 8'h55, 1, 2),  // R2 key
    vw(I, 8'h20, 1, 6), vr(D, 8'h87, 1, 6), vw(I, 8'h21, 1, 6), vr(D, 8'h16, 1, 6),  // R6 id
    vr(I, 8'h21, 1, 10),                                                             // R10 index read
    vw(I, 8'h24, 1, 8), vr(D, 8'h00, 1, 8), vw(D, 8'hA5, 1, 8), vr(D, 8'hA5, 1, 8),  // R8 segment
    vw(I, 8'h07, 1, 7), vw(D, 8'h07, 1, 7), vr(D, 8'h07, 1, 7),                      // R7 selector
    vw(I, 8'h64, 1, 7), vw(D, 8'h12, 1, 7), vw(I, 8'h65, 1, 7), vw(D, 8'h34, 1, 7),
    vr(D, 8'h34, 1, 7), vw(I, 8'h64, 1, 7), vr(D, 8'h12, 1, 7),                      // R7 base bytes
    vw(I, 8'h30, 1, 10), vr(D, 8'h00, 1, 10),                                        // R10 unassigned
    vw(I, 8'h02, 1, 9), vw(D, 8'h01, 1, 9), vw(D, 8'h02, 0, 9),                      // R9 exit
    vr(D, 8'hFF, 0, 9), vr(I, 8'hFF, 0, 10),
    vw(I, 8'h87, 0, 4), vw(I, 8'h01, 0, 4), vw(I, 8'h87, 0, 4),                      // R4 restart on 0x87
    vw(I, 8'h01, 0, 4), vw(I, 8'h55, 0, 4), vw(I, 8'h55, 1, 4),
    vw(I, 8'h07, 1, 7), vw(D, 8'h03, 1, 7), vw(I, 8'h64, 1, 7), vr(D, 8'h00, 1, 7),  // R7 other device
    vw(D, 8'h99, 1, 7), vw(I, 8'h07, 1, 7), vw(D, 8'h07, 1, 7), vw(I, 8'h64, 1, 7),
    vr(D, 8'h12, 1, 7),
    vw(I, 8'h24, 1, 8), vr(D, 8'hA5, 1, 8),                                          // R8 kept
    vw(I, 8'h02, 1, 9), vw(D, 8'h02, 0, 9),
    vw(I, 8'h87, 0, 4), vw(I, 8'h01, 0, 4), vw(I, 8'h55, 0, 4),                      // R4 broken key
    vw(I, 8'h00, 0, 4), vw(I, 8'h55, 0, 4), vr(D, 8'hFF, 0, 4)
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    portSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic sel);
    @(negedge clk);
    portSel = sel; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; altBase = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset(1'b0);
    // R1 reset state
    check(1, {15'd0, cfgActive}, 16'd0, "active after reset");
    check(1, spiBase, 16'h0000, "base after reset");
    check(1, {8'd0, rdData}, 16'h00FF, "read byte after reset");

    for (int n = 0; n < NV; n++) begin
      logic [14:0] v;
      v = VEC[n];
      if (v[14]) begin
        doRead(v[13]);
        check(int'(v[3:0]), {8'd0, rdData}, {8'd0, v[12:5]}, $sformatf("vector %0d read", n));
      end else begin
        doWrite(v[13], v[12:5]);
      end
      check(int'(v[3:0]), {15'd0, cfgActive}, {15'd0, v[4]}, $sformatf("vector %0d active", n));
    end

    // R7 base address visible at the output
    check(7, spiBase, 16'h1234, "base output");
    // R5 locked data write leaves base untouched
    doWrite(D, 8'hEE);
    check(5, spiBase, 16'h1234, "base after locked write");

    // R1 reset with alternate strap
    doReset(1'b1);
    check(1, {15'd0, cfgActive}, 16'd0, "active after second reset");
    check(1, spiBase, 16'h0000, "base after second reset");
    // R3 primary last byte rejected, alternate accepted
    doWrite(I, 8'h87); doWrite(I, 8'h01); doWrite(I, 8'h55); doWrite(I, 8'h55);
    check(3, {15'd0, cfgActive}, 16'd0, "primary key on alternate strap");
    doWrite(I, 8'h87); doWrite(I, 8'h01); doWrite(I, 8'h55);
    check(3, {15'd0, cfgActive}, 16'd0, "three of four bytes");
    doWrite(I, 8'hAA);
    check(3, {15'd0, cfgActive}, 16'd1, "alternate key");
    // R8 segment byte back to reset value
    doWrite(I, 8'h24); doRead(D);
    check(8, {8'd0, rdData}, 16'h0000, "segment after reset");
    // R11 read byte holds without strobe
    doRead(I);
    check(11, {8'd0, rdData}, 16'h0024, "index read");
    doWrite(I, 8'h20);
    repeat (3) @(negedge clk);
    check(11, {8'd0, rdData}, 16'h0024, "held without read");
    doRead(D);
    check(11, {8'd0, rdData}, 16'h0087, "reloaded on read");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule